// File: doc/BRIEF.md
# Triggered Scan Acquisition Controller

This block sequences multichannel scans for an ADC front end. Every clock cycle is one timebase tick. Down-counters built on that tick produce one conversion strobe per channel and report the channel index with it. Software programs these values: channels per scan, scans per burst, the sample interval between channels, the scan interval between scan starts, and the number of bursts. A start pulse arms the block. A stop pulse returns it to idle from any state.

The block has two modes. In burst mode, each active trigger edge launches a fixed number of scans. Edges that arrive while a burst is running are dropped. After the programmed number of bursts the block reports done, and a burst count of zero keeps it serving bursts until it is stopped. In gated mode, scans run while the synchronised trigger sits at its active level. When the level goes inactive, the block holds at the next scan boundary. The run ends after the programmed number of scans.

The trigger input passes through a two-flop synchroniser before any level or edge is taken from it. An unsafe configuration is refused when start is issued.

Top module: `acq_scan_ctrl`

## Requirements
- R1: After reset, conv_o, busy_o, acq_done_o and cfg_err_o are all 0. A start with a valid configuration raises busy_o on the next cycle, and no strobe occurs before a trigger.
- R2: With pol_i=0 the active trigger is a rising edge in burst mode and a high level in gated mode. With pol_i=1 these are a falling edge and a low level. The first strobe of a launched scan appears in the third cycle after trig_i changes, meaning after the third rising clock edge.
- R3: A scan gives chans_i strobes with chan_o running 0 to chans_i-1, one strobe every samp_ivl_i cycles. scan_done_o is high only together with the strobe of the last channel.
- R4: The scans of one burst start scan_ivl_i cycles apart. After exactly scans_i scans the block waits for the next trigger and stays busy.
- R5: A trigger edge that arrives while a burst is running launches nothing extra.
- R6: With retrig_i=N>0, acq_done_o rises one cycle after the last strobe of burst N and busy_o falls. The total strobe count is chans_i*scans_i*N.
- R7: With retrig_i=0, bursts keep being served and acq_done_o stays low until stop.
- R8: In gated mode, scans run only while the level is active. An inactive level takes effect at the next scan boundary, so the current scan completes. Scans resume when the level returns, and the run is done after scans_i scans in total.
- R9: A start is refused and cfg_err_o is set, with busy_o staying 0, in any of these cases: scan_ivl_i < samp_ivl_i*chans_i, chans_i=0, chans_i above the channel limit, scans_i=0, or samp_ivl_i=0. The next accepted start clears cfg_err_o.
- R10: stop_i makes busy_o 0 on the next cycle from any state, and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arm pulse from software |
| stop_i | input | 1 | Abort pulse from software |
| gated_i | input | 1 | 1 selects gated mode, 0 selects burst mode |
| pol_i | input | 1 | Trigger polarity: 0 rising/high, 1 falling/low |
| trig_i | input | 1 | Asynchronous trigger input |
| chans_i | input | 5 | Channels per scan |
| scans_i | input | 16 | Scans per burst (gated mode: scans in total) |
| samp_ivl_i | input | 16 | Cycles between strobes within a scan |
| scan_ivl_i | input | 16 | Cycles between scan starts |
| retrig_i | input | 16 | Bursts to serve; 0 means unlimited |
| conv_o | output | 1 | Conversion strobe |
| chan_o | output | 4 | Channel index of the strobe |
| scan_done_o | output | 1 | Last strobe of a scan |
| acq_done_o | output | 1 | Acquisition finished |
| busy_o | output | 1 | Armed or scanning |
| cfg_err_o | output | 1 | Last start refused |

## Verification
A trigger change driven between clock edges gives its first strobe after the third rising edge: two flops for synchronisation, then the launch register. The bench therefore expects conv_o low two samples after the change and high, with channel 0, on the third sample. Later strobes are timed against the cycle of the previous strobe (samp_ivl_i) or the previous scan start (scan_ivl_i). acq_done_o is expected one cycle after the final strobe, and busy_o and cfg_err_o one cycle after stop or start. All outputs are sampled on the falling edge and inputs are driven just after it, so every expected value falls on a whole cycle count.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SCAN = 2'd2,
    ST_DONE = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_trig_cond.sv
module acq_trig_cond #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pol_i,
  output logic level_o,
  output logic edge_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= trig_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_N-2:0], trig_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_N-1];

  assign level_o = sync_q[SYNC_N-1] ^ pol_i;
  assign edge_o  = level_o & ~(prev_q ^ pol_i);

  // R2: an edge event lasts one cycle
  a_r2_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/acq_cfg_check.sv
module acq_cfg_check #(
  parameter int CNT_W  = 16,
  parameter int CH_MAX = 16,
  parameter int SCN_W  = 16,
  localparam int CHN_W = $clog2(CH_MAX) + 1
) (
  input  logic [CHN_W-1:0] chans_i,
  input  logic [SCN_W-1:0] scans_i,
  input  logic [CNT_W-1:0] samp_ivl_i,
  input  logic [CNT_W-1:0] scan_ivl_i,
  output logic             ok_o
);
  localparam int PROD_W = CNT_W + CHN_W;
  logic [PROD_W-1:0] need;

  assign need = PROD_W'(samp_ivl_i) * PROD_W'(chans_i);
  assign ok_o = (chans_i != '0) && (chans_i <= CHN_W'(CH_MAX)) &&
                (scans_i != '0) && (samp_ivl_i != '0) &&
                (PROD_W'(scan_ivl_i) >= need);
endmodule

// File: rtl/acq_scan_timer.sv
module acq_scan_timer #(
  parameter int CNT_W  = 16,
  parameter int CH_MAX = 16,
  localparam int CH_W  = $clog2(CH_MAX),
  localparam int CHN_W = CH_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] samp_ivl_i,
  input  logic [CNT_W-1:0] scan_ivl_i,
  input  logic [CHN_W-1:0] chans_i,
  output logic             conv_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             scan_end_o,
  output logic             slot_end_o
);
  logic [CNT_W-1:0] samp_cnt_q, scan_cnt_q;
  logic [CH_W-1:0]  chan_q;
  logic             in_scan_q, slot_q;

  assign conv_o     = in_scan_q && (samp_cnt_q == '0);
  assign chan_o     = chan_q;
  assign scan_end_o = conv_o && (CHN_W'(chan_q) == chans_i - CHN_W'(1));
  assign slot_end_o = slot_q && (scan_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_cnt_q <= '0;
      scan_cnt_q <= '0;
      chan_q     <= '0;
      in_scan_q  <= 1'b0;
      slot_q     <= 1'b0;
    end else if (halt_i) begin
      in_scan_q  <= 1'b0;
      slot_q     <= 1'b0;
      chan_q     <= '0;
    end else if (launch_i) begin
      in_scan_q  <= 1'b1;
      slot_q     <= 1'b1;
      samp_cnt_q <= '0;
      scan_cnt_q <= scan_ivl_i - CNT_W'(1);
      chan_q     <= '0;
    end else begin
      if (slot_q) begin
        if (scan_cnt_q == '0) slot_q <= 1'b0;
        else                  scan_cnt_q <= scan_cnt_q - CNT_W'(1);
      end
      if (in_scan_q) begin
        if (conv_o) begin
          samp_cnt_q <= samp_ivl_i - CNT_W'(1);
          if (scan_end_o) begin
            in_scan_q <= 1'b0;
            chan_q    <= '0;
          end else begin
            chan_q    <= chan_q + CH_W'(1);
          end
        end else begin
          samp_cnt_q <= samp_cnt_q - CNT_W'(1);
        end
      end
    end
  end

  // R3: strobe channel never exceeds the programmed count
  a_r3_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> (CHN_W'(chan_o) < chans_i));
  // R4: every scan has finished by the end of its interval slot
  a_r4_scan_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_o |-> (!in_scan_q || scan_end_o));
endmodule

// File: rtl/acq_scan_ctrl.sv
module acq_scan_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CH_MAX = 16,
  parameter int SCN_W  = 16,
  parameter int RT_W   = 16,
  parameter int SYNC_N = 2,
  localparam int CH_W  = $clog2(CH_MAX),
  localparam int CHN_W = CH_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             gated_i,
  input  logic             pol_i,
  input  logic             trig_i,
  input  logic [CHN_W-1:0] chans_i,
  input  logic [SCN_W-1:0] scans_i,
  input  logic [CNT_W-1:0] samp_ivl_i,
  input  logic [CNT_W-1:0] scan_ivl_i,
  input  logic [RT_W-1:0]  retrig_i,
  output logic             conv_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             scan_done_o,
  output logic             acq_done_o,
  output logic             busy_o,
  output logic             cfg_err_o
);
  acq_state_e       state_q;
  logic [SCN_W-1:0] scans_q;
  logic [RT_W-1:0]  bursts_q;
  logic             err_q;

  logic level, edge_ev, cfg_ok;
  logic scan_end, slot_end, launch, halt;
  logic burst_fin, last_burst, pause, go;

  acq_trig_cond #(.SYNC_N(SYNC_N)) u_trig (
    .clk_i, .rst_ni, .trig_i, .pol_i,
    .level_o(level), .edge_o(edge_ev)
  );

  acq_cfg_check #(.CNT_W(CNT_W), .CH_MAX(CH_MAX), .SCN_W(SCN_W)) u_cfg (
    .chans_i, .scans_i, .samp_ivl_i, .scan_ivl_i, .ok_o(cfg_ok)
  );

  acq_scan_timer #(.CNT_W(CNT_W), .CH_MAX(CH_MAX)) u_timer (
    .clk_i, .rst_ni,
    .launch_i(launch), .halt_i(halt),
    .samp_ivl_i, .scan_ivl_i, .chans_i,
    .conv_o, .chan_o,
    .scan_end_o(scan_end), .slot_end_o(slot_end)
  );

  assign burst_fin  = (state_q == ST_SCAN) && scan_end &&
                      (scans_q + SCN_W'(1) == scans_i);
  assign last_burst = (retrig_i != '0) && (bursts_q + RT_W'(1) == retrig_i);
  assign pause      = gated_i && !level;
  assign go         = gated_i ? level : edge_ev;
  assign launch     = !stop_i &&
                      (((state_q == ST_WAIT) && go) ||
                       ((state_q == ST_SCAN) && slot_end && !burst_fin && !pause));
  assign halt       = stop_i || burst_fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      scans_q  <= '0;
      bursts_q <= '0;
      err_q    <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          if (cfg_ok) begin
            state_q  <= ST_WAIT;
            scans_q  <= '0;
            bursts_q <= '0;
            err_q    <= 1'b0;
          end else begin
            err_q    <= 1'b1;
          end
        end
        ST_WAIT: if (launch) begin
          state_q <= ST_SCAN;
          if (!gated_i) scans_q <= '0;
        end
        ST_SCAN: begin
          if (burst_fin) begin
            bursts_q <= bursts_q + RT_W'(1);
            scans_q  <= '0;
            state_q  <= (gated_i || last_burst) ? ST_DONE : ST_WAIT;
          end else begin
            if (scan_end) scans_q <= scans_q + SCN_W'(1);
            if (slot_end && pause) state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_done_o = scan_end;
  assign acq_done_o  = (state_q == ST_DONE);
  assign busy_o      = (state_q == ST_WAIT) || (state_q == ST_SCAN);
  assign cfg_err_o   = err_q;

  // R1: strobes only while busy
  a_r1_conv_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> busy_o);
  // R10: stop idles the block on the next cycle
  a_r10_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_o && !conv_o);
  // R9: a refused start leaves the block idle
  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o);
  // R6: done follows the final scan strobe
  a_r6_done_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_done_o) |-> $past(scan_done_o));
endmodule

// File: tb/acq_scan_ctrl_tb.sv
module acq_scan_ctrl_tb_top;
  localparam int CNT_W = 16, CH_MAX = 16, SCN_W = 16, RT_W = 16;
  localparam int CH_W = $clog2(CH_MAX), CHN_W = CH_W + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, gated_i = 0, pol_i = 0, trig_i = 0;
  logic [CHN_W-1:0] chans_i = 1;
  logic [SCN_W-1:0] scans_i = 1;
  logic [CNT_W-1:0] samp_ivl_i = 1, scan_ivl_i = 1;
  logic [RT_W-1:0]  retrig_i = 1;
  logic conv_o, scan_done_o, acq_done_o, busy_o, cfg_err_o;
  logic [CH_W-1:0] chan_o;

  acq_scan_ctrl dut_i (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int conv_total = 0;
  int m_chans = 1, m_samp = 1, m_sivl = 1, m_scans = 1;
  bit m_gated = 0;
  int m_exp_chan = 0, m_prev = 0, m_sstart = 0, m_sidx = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_total(int ch, int sc, int nb);
    return ch * sc * nb;
  endfunction

  function automatic int burst_span(int ch, int sa, int si, int sc);
    return (sc - 1) * si + (ch - 1) * sa;
  endfunction

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (rst_ni) begin
    if (conv_o) begin
      conv_total++;
      chk(int'(chan_o) == m_exp_chan, "R3 chan", chan_o, m_exp_chan);
      chk(scan_done_o == (m_exp_chan == m_chans - 1), "R3 scan_done", scan_done_o,
          int'(m_exp_chan == m_chans - 1));
      if (m_exp_chan != 0)
        chk(cyc - m_prev == m_samp, "R3 spacing", cyc - m_prev, m_samp);
      else if (m_sidx != 0 && !m_gated)
        chk(cyc - m_sstart == m_sivl, "R4 scan spacing", cyc - m_sstart, m_sivl);
      if (m_exp_chan == 0) m_sstart = cyc;
      m_prev = cyc;
      if (m_exp_chan == m_chans - 1) begin
        m_exp_chan = 0;
        m_sidx = (m_sidx + 1 == m_scans) ? 0 : m_sidx + 1;
      end else m_exp_chan++;
    end else if (scan_done_o) chk(0, "R3 scan_done alone", 1, 0);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic setup(bit g, bit p, int ch, int sa, int si, int sc, int rt);
    gated_i = g; pol_i = p; trig_i = p;
    chans_i = CHN_W'(ch); samp_ivl_i = CNT_W'(sa); scan_ivl_i = CNT_W'(si);
    scans_i = SCN_W'(sc); retrig_i = RT_W'(rt);
    m_gated = g; m_chans = ch; m_samp = sa; m_sivl = si; m_scans = sc;
    m_exp_chan = 0; m_sidx = 0;
    tick(4);
  endtask

  task automatic pulse_start();
    start_i = 1; tick(1); start_i = 0;
  endtask

  task automatic pulse_stop();
    stop_i = 1; tick(1); stop_i = 0;
    chk(busy_o == 0, "R10 busy after stop", busy_o, 0);
    chk(conv_o == 0, "R10 conv after stop", conv_o, 0);
  endtask

  // drive trigger active and check first-strobe latency
  task automatic fire(string req);
    trig_i = ~pol_i;
    tick(2);
    chk(conv_o == 0, req, conv_o, 0);
    tick(1);
    chk(conv_o == 1 && chan_o == 0, req, conv_o, 1);
  endtask

  task automatic run_post(bit p, int ch, int sa, int si, int sc, int rt);
    int span, base, start_cnt;
    setup(0, p, ch, sa, si, sc, rt);
    span = burst_span(ch, sa, si, sc);
    start_cnt = conv_total;
    pulse_start();
    chk(busy_o == 1, "R1 busy after start", busy_o, 1);
    chk(cfg_err_o == 0, "R1 no error", cfg_err_o, 0);
    tick(8);
    chk(conv_total == start_cnt, "R1 no strobe before trigger", conv_total, start_cnt);
    for (int b = 0; b < rt; b++) begin
      base = conv_total;
      fire("R2 trigger latency");
      tick(1); trig_i = p;
      if (span >= 8) begin
        tick(1); trig_i = ~p;   // R5 mid-burst edge
        tick(2); trig_i = p;
      end
      tick(span + 6);
      chk(conv_total - base == ch * sc, "R4/R5 strobes per burst", conv_total - base, ch * sc);
      if (b < rt - 1) chk(busy_o == 1, "R4 waits for trigger", busy_o, 1);
    end
    chk(acq_done_o == 1, "R6 done", acq_done_o, 1);
    chk(busy_o == 0, "R6 busy low", busy_o, 0);
    chk(conv_total - start_cnt == exp_total(ch, sc, rt), "R6 total",
        conv_total - start_cnt, exp_total(ch, sc, rt));
  endtask

  initial begin
    int base, guard, ch, sa, si, sc, rt;
    bit p;
    void'($urandom(32'h1c5e_a011));
    tick(2);
    rst_ni = 1;
    tick(1);
    chk(conv_o == 0 && busy_o == 0, "R1 reset idle", busy_o, 0);
    chk(acq_done_o == 0 && cfg_err_o == 0, "R1 reset flags", acq_done_o, 0);

    // directed: span long enough for an ignored mid-burst edge
    run_post(0, 3, 2, 7, 3, 2);
    run_post(1, 1, 1, 5, 2, 1);

    // random burst-mode runs
    for (int k = 0; k < 6; k++) begin
      ch = 1 + int'($urandom_range(3));
      sa = 1 + int'($urandom_range(2));
      si = ch * sa + int'($urandom_range(3));
      if (si < 5) si = 5;
      sc = 1 + int'($urandom_range(2));
      rt = 1 + int'($urandom_range(2));
      p  = 1'($urandom_range(1));
      run_post(p, ch, sa, si, sc, rt);
    end

    // R7: unlimited bursts
    setup(0, 0, 2, 1, 4, 2, 0);
    base = conv_total;
    pulse_start();
    for (int b = 0; b < 4; b++) begin
      fire("R2 latency (R7 run)");
      tick(1); trig_i = 0;
      tick(12);
    end
    chk(conv_total - base == exp_total(2, 2, 4), "R7 bursts keep running",
        conv_total - base, exp_total(2, 2, 4));
    chk(busy_o == 1 && acq_done_o == 0, "R7 still armed", busy_o, 1);
    pulse_stop();

    // R10: stop in the middle of a scan
    setup(0, 0, 4, 3, 12, 3, 1);
    pulse_start();
    fire("R2 latency (R10 run)");
    trig_i = 0;
    tick(2);
    base = conv_total;
    pulse_stop();
    tick(40);
    chk(conv_total == base, "R10 no strobe after stop", conv_total, base);
    chk(acq_done_o == 0, "R10 not done", acq_done_o, 0);

    // R9: rejected configurations
    setup(0, 0, 3, 2, 5, 1, 1);
    pulse_start();
    chk(cfg_err_o == 1, "R9 interval too short", cfg_err_o, 1);
    chk(busy_o == 0, "R9 stays idle", busy_o, 0);
    setup(0, 0, 0, 2, 5, 1, 1);
    pulse_start();
    chk(cfg_err_o == 1 && busy_o == 0, "R9 zero channels", cfg_err_o, 1);
    setup(0, 0, 2, 2, 4, 0, 1);
    pulse_start();
    chk(cfg_err_o == 1 && busy_o == 0, "R9 zero scans", cfg_err_o, 1);
    setup(0, 0, 2, 2, 4, 1, 1);
    pulse_start();
    chk(cfg_err_o == 0 && busy_o == 1, "R9 valid start clears error", cfg_err_o, 0);
    pulse_stop();

    // R8: gated mode with a pause
    p = 1'($urandom_range(1));
    setup(1, p, 2, 2, 6, 5, 1);
    base = conv_total;
    pulse_start();
    tick(10);
    chk(conv_total == base && busy_o == 1, "R8 held while inactive", conv_total, base);
    fire("R2 level latency (R8)");
    guard = 0;
    while (conv_total - base < 3 && guard < 60) begin tick(1); guard++; end
    trig_i = p;
    tick(30);
    chk(conv_total - base == 4, "R8 pause at scan boundary", conv_total - base, 4);
    chk(busy_o == 1 && acq_done_o == 0, "R8 paused but armed", busy_o, 1);
    trig_i = ~p;
    tick(45);
    chk(conv_total - base == 10, "R8 resume to full count", conv_total - base, 10);
    chk(acq_done_o == 1 && busy_o == 0, "R8 done", acq_done_o, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule